// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style core. Each cycle it receives the working register value W, a file-register operand and an immediate literal, together with an operation code. It returns the 8-bit result, and it states where that result should be written: to W, to the file register, or nowhere. It also produces a skip request for the conditional-skip operations. The register file, instruction fetch and call stack sit outside the block.

The block holds the three status flags itself: carry, digit carry and zero. Each operation updates only the flags its rules name and leaves the others alone. The two rotates consume the stored carry and write a new one.

A one-bit literal select picks the immediate value instead of the file operand. It applies to add, subtract, AND, OR, XOR and move, and a literal-form result always goes to W. For file forms that have a free destination, a destination bit chooses W (0) or the file register (1). A strobe input marks a valid operation, and the flags change only on clock edges where it is high.

Top module: `accu_alu`

## Requirements
- R1: While reset is high, and on the first cycle after it, the carry, digit carry and zero outputs read 0. With `valid_i` low, `wr_w_o`, `wr_f_o` and `skip_o` are 0.
- R2: Add (code 0) gives result = W + operand mod 256. Carry becomes bit 8 of the 9-bit sum, digit carry becomes the carry out of bit 3, and zero is set when the result is 0.
- R3: Subtract (code 1) gives result = operand − W mod 256, so the literal form is k − W. Carry is 1 when operand ≥ W (no borrow). Digit carry is 1 when operand[3:0] ≥ W[3:0]. Zero follows the result.
- R4: AND (2), OR (3), XOR (4), file move (5), clear (7, result 0), increment (8), decrement (9) and complement (10) update only the zero flag. Move with the literal selected (k to W) and store-W (6, W to file) change no flag.
- R5: Rotate left (12) gives {f[6:0], C}, and its new carry is f[7]. Rotate right (13) gives {C, f[7:1]}, and its new carry is f[0]. Digit carry and zero are unchanged.
- R6: Nibble swap (11) gives {f[3:0], f[7:4]} and changes no flag.
- R7: Bit clear (14) and bit set (15) force bit `bit_i` of f to 0 or 1. The result always goes to the file register, and no flag changes.
- R8: Test-skip-if-clear (16) asserts skip when f[bit_i] is 0. Test-skip-if-set (17) asserts skip when it is 1. Neither writes a result or changes a flag.
- R9: Increment-and-skip (18) and decrement-and-skip (19) produce f+1 and f−1 mod 256. They assert skip when that result is 0, follow the destination bit, and change no flag.
- R10: Literal forms write only W, whatever the destination bit. File forms with a destination write W when `dest_f_i` is 0 and the file register when it is 1. At most one write strobe is high in any cycle.
- R11: With `valid_i` low, or with an unused code (20–31), the flags keep their value and no write or skip is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation valid this cycle |
| op_i | input | 5 | Operation code |
| use_lit_i | input | 1 | Use literal instead of file operand |
| dest_f_i | input | 1 | Destination: 0 = W, 1 = file |
| w_i | input | 8 | Working register value |
| file_i | input | 8 | File register operand |
| lit_i | input | 8 | Immediate literal |
| bit_i | input | 3 | Bit index for bit operations |
| result_o | output | 8 | Operation result |
| wr_w_o | output | 1 | Write result to W |
| wr_f_o | output | 1 | Write result to the file register |
| skip_o | output | 1 | Skip the next instruction |
| carry_o | output | 1 | Carry / no-borrow flag |
| dcarry_o | output | 1 | Digit carry flag |
| zero_o | output | 1 | Zero flag |

## Verification
A rotate reads the stored carry to fill its vacated bit, and on the same clock edge it overwrites that carry with the bit shifted out. The bench provokes this with runs of rotates, so every rotate depends on the carry left by the previous operation, whether that was a rotate or an add or subtract. The bench judges each one against its own flag model, which is updated one edge after the operation. Increment-and-skip likewise produces a written result and a skip decision in the same cycle while leaving the zero flag alone. The bench checks all three for every operand value and both destinations.

// File: rtl/accu_alu_pkg.sv
package accu_alu_pkg;

    localparam int DW  = 8;
    localparam int NIB = DW / 2;
    localparam int BW  = $clog2(DW);
    localparam int NFLAG = 3;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [4:0] {
        OP_ADD      = 5'd0,
        OP_SUB      = 5'd1,
        OP_AND      = 5'd2,
        OP_OR       = 5'd3,
        OP_XOR      = 5'd4,
        OP_MOVE     = 5'd5,
        OP_STORE_W  = 5'd6,
        OP_CLEAR    = 5'd7,
        OP_INC      = 5'd8,
        OP_DEC      = 5'd9,
        OP_INV      = 5'd10,
        OP_NSWAP    = 5'd11,
        OP_ROTL     = 5'd12,
        OP_ROTR     = 5'd13,
        OP_BCLR     = 5'd14,
        OP_BSET     = 5'd15,
        OP_SKIP_CLR = 5'd16,
        OP_SKIP_SET = 5'd17,
        OP_INC_SKZ  = 5'd18,
        OP_DEC_SKZ  = 5'd19
    } alu_op_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DEST = 2'd1,
        TGT_FILE = 2'd2,
        TGT_W    = 2'd3
    } tgt_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flags_t;

    typedef struct packed {
        word_t  data;
        flags_t val;
        flags_t upd;
        tgt_e   tgt;
        logic   skip;
    } alu_res_t;

    function automatic logic takes_literal(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
               (op == OP_OR)  || (op == OP_XOR) || (op == OP_MOVE);
    endfunction

    function automatic word_t swap_nibbles(word_t v);
        return {v[NIB-1:0], v[DW-1:NIB]};
    endfunction

endpackage

// File: rtl/accu_alu_addsub.sv
module accu_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         half_o
);
    localparam int H  = W / 2;
    localparam int HU = W - H;

    logic [W-1:0] b_eff;
    logic [H:0]   lo;
    logic [HU:0]  hi;

    // subtract is a + ~b + 1: carry out means no borrow
    assign b_eff = sub_i ? ~b_i : b_i;
    assign lo    = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, sub_i};
    assign hi    = {1'b0, a_i[W-1:H]} + {1'b0, b_eff[W-1:H]} + {{HU{1'b0}}, lo[H]};

    assign sum_o   = {hi[HU-1:0], lo[H-1:0]};
    assign carry_o = hi[HU];
    assign half_o  = lo[H];

endmodule

// File: rtl/accu_alu_unit.sv
module accu_alu_unit
    import accu_alu_pkg::*;
(
    input  alu_op_e        op_i,
    input  logic           use_lit_i,
    input  word_t          w_i,
    input  word_t          file_i,
    input  word_t          lit_i,
    input  logic [BW-1:0]  bit_i,
    input  logic           carry_i,
    output word_t          opnd_o,
    output alu_res_t       res_o
);
    word_t as_sum;
    logic  as_c;
    logic  as_dc;
    word_t mask;
    logic  lit_sel;
    word_t opnd;

    assign lit_sel = use_lit_i && takes_literal(op_i);
    assign opnd    = lit_sel ? lit_i : file_i;
    assign opnd_o  = opnd;
    assign mask    = word_t'(1) << bit_i;

    accu_alu_addsub #(.W(DW)) addsub_i (
        .a_i     (opnd),
        .b_i     (w_i),
        .sub_i   (op_i == OP_SUB),
        .sum_o   (as_sum),
        .carry_o (as_c),
        .half_o  (as_dc)
    );

    always_comb begin
        res_o      = '0;
        res_o.tgt  = lit_sel ? TGT_W : TGT_DEST;
        unique case (op_i)
            OP_ADD, OP_SUB: begin
                res_o.data   = as_sum;
                res_o.val.c  = as_c;
                res_o.val.dc = as_dc;
                res_o.upd    = '{c: 1'b1, dc: 1'b1, z: 1'b1};
            end
            OP_AND: begin res_o.data = opnd & w_i; res_o.upd.z = 1'b1; end
            OP_OR:  begin res_o.data = opnd | w_i; res_o.upd.z = 1'b1; end
            OP_XOR: begin res_o.data = opnd ^ w_i; res_o.upd.z = 1'b1; end
            OP_MOVE: begin
                res_o.data  = opnd;
                res_o.upd.z = !lit_sel;
            end
            OP_STORE_W: begin
                res_o.data = w_i;
                res_o.tgt  = TGT_FILE;
            end
            OP_CLEAR: begin res_o.data = '0;          res_o.upd.z = 1'b1; end
            OP_INC:   begin res_o.data = opnd + 1'b1; res_o.upd.z = 1'b1; end
            OP_DEC:   begin res_o.data = opnd - 1'b1; res_o.upd.z = 1'b1; end
            OP_INV:   begin res_o.data = ~opnd;       res_o.upd.z = 1'b1; end
            OP_NSWAP: res_o.data = swap_nibbles(opnd);
            OP_ROTL: begin
                res_o.data  = {opnd[DW-2:0], carry_i};
                res_o.val.c = opnd[DW-1];
                res_o.upd.c = 1'b1;
            end
            OP_ROTR: begin
                res_o.data  = {carry_i, opnd[DW-1:1]};
                res_o.val.c = opnd[0];
                res_o.upd.c = 1'b1;
            end
            OP_BCLR: begin res_o.data = opnd & ~mask; res_o.tgt = TGT_FILE; end
            OP_BSET: begin res_o.data = opnd | mask;  res_o.tgt = TGT_FILE; end
            OP_SKIP_CLR: begin
                res_o.data = opnd & mask;
                res_o.tgt  = TGT_NONE;
                res_o.skip = ~|(opnd & mask);
            end
            OP_SKIP_SET: begin
                res_o.data = opnd & mask;
                res_o.tgt  = TGT_NONE;
                res_o.skip = |(opnd & mask);
            end
            OP_INC_SKZ: begin
                res_o.data = opnd + 1'b1;
                res_o.skip = (opnd + 1'b1) == '0;
            end
            OP_DEC_SKZ: begin
                res_o.data = opnd - 1'b1;
                res_o.skip = (opnd - 1'b1) == '0;
            end
            default: res_o.tgt = TGT_NONE;
        endcase
        res_o.val.z = (res_o.data == '0);
    end

endmodule

// File: rtl/accu_alu_flags.sv
module accu_alu_flags #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [NF-1:0] upd_i,
    input  logic [NF-1:0] val_i,
    output logic [NF-1:0] q_o
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q_o[i] <= 1'b0;
            else if (en_i && upd_i[i])
                q_o[i] <= val_i[i];
        end
    end

    // R11: an idle cycle leaves every flag alone
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(q_o));

endmodule

// File: rtl/accu_alu.sv
module accu_alu
    import accu_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [4:0]    op_i,
    input  logic          use_lit_i,
    input  logic          dest_f_i,
    input  logic [DW-1:0] w_i,
    input  logic [DW-1:0] file_i,
    input  logic [DW-1:0] lit_i,
    input  logic [BW-1:0] bit_i,
    output logic [DW-1:0] result_o,
    output logic          wr_w_o,
    output logic          wr_f_o,
    output logic          skip_o,
    output logic          carry_o,
    output logic          dcarry_o,
    output logic          zero_o
);
    alu_op_e  op;
    alu_res_t res;
    flags_t   flags_q;
    word_t    opnd;

    assign op = alu_op_e'(op_i);

    accu_alu_unit unit_i (
        .op_i      (op),
        .use_lit_i (use_lit_i),
        .w_i       (w_i),
        .file_i    (file_i),
        .lit_i     (lit_i),
        .bit_i     (bit_i),
        .carry_i   (flags_q.c),
        .opnd_o    (opnd),
        .res_o     (res)
    );

    accu_alu_flags #(.NF(NFLAG)) flags_i (
        .clk   (clk),
        .rst   (rst),
        .en_i  (valid_i),
        .upd_i (res.upd),
        .val_i (res.val),
        .q_o   (flags_q)
    );

    assign result_o = res.data;
    assign wr_w_o   = valid_i && ((res.tgt == TGT_W) || ((res.tgt == TGT_DEST) && !dest_f_i));
    assign wr_f_o   = valid_i && ((res.tgt == TGT_FILE) || ((res.tgt == TGT_DEST) && dest_f_i));
    assign skip_o   = valid_i && res.skip;
    assign carry_o  = flags_q.c;
    assign dcarry_o = flags_q.dc;
    assign zero_o   = flags_q.z;

    logic [DW:0] chk_add9;
    assign chk_add9 = {1'b0, w_i} + {1'b0, opnd};

    p_one_target_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_w_o, wr_f_o}));

    p_lit_to_w_r10: assert property (@(posedge clk) disable iff (rst)
        (valid_i && use_lit_i && op == OP_ADD) |-> (wr_w_o && !wr_f_o));

    p_add_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op == OP_ADD) |=> (carry_o == $past(chk_add9[DW])));

    p_sub_borrow_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op == OP_SUB) |=> (carry_o == $past(opnd >= w_i)));

    p_rotl_carry_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op == OP_ROTL) |=>
            (carry_o == $past(file_i[DW-1]) && $stable({dcarry_o, zero_o})));

    p_swap_noflag_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op == OP_NSWAP) |=> $stable({carry_o, dcarry_o, zero_o}));

    p_btest_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op == OP_SKIP_CLR) |-> (skip_o == !file_i[bit_i] && !wr_w_o && !wr_f_o));

    p_decskz_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op == OP_DEC_SKZ) |-> (skip_o == (file_i == word_t'(1))));

endmodule

// File: tb/accu_alu_tb.sv
module accu_alu_tb_top;
    import accu_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid_i = 1'b0;
    logic [4:0] op_i = '0;
    logic       use_lit_i = 1'b0;
    logic       dest_f_i = 1'b0;
    logic [7:0] w_i = '0, file_i = '0, lit_i = '0;
    logic [2:0] bit_i = '0;
    logic [7:0] result_o;
    logic       wr_w_o, wr_f_o, skip_o, carry_o, dcarry_o, zero_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit mc = 0, mdc = 0, mz = 0;

    always #4 clk = ~clk;

    accu_alu dut_i (.*);

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // one valid operation: drive at negedge, check outputs mid-cycle, flags after the edge
    task automatic run(int code, bit lit, bit d, int w, int f, int k, int b, string tag);
        bit litf = lit && (code inside {0, 1, 2, 3, 4, 5});
        int a = litf ? k : f;
        int res = 0;
        int tgt = litf ? 3 : 1;
        bit ec = mc, edc = mdc, ez = mz, sk = 0, setz = 0;
        case (code)
            0: begin res = (w + a) & 255; ec = (w + a) > 255;
                     edc = ((w & 15) + (a & 15)) > 15; setz = 1; end
            1: begin res = (a - w) & 255; ec = a >= w;
                     edc = (a & 15) >= (w & 15); setz = 1; end
            2: begin res = a & w; setz = 1; end
            3: begin res = a | w; setz = 1; end
            4: begin res = a ^ w; setz = 1; end
            5: begin res = a; setz = !litf; end
            6: begin res = w; tgt = 2; end
            7: begin res = 0; setz = 1; end
            8: begin res = (f + 1) & 255; setz = 1; end
            9: begin res = (f + 255) & 255; setz = 1; end
            10: begin res = 255 - f; setz = 1; end
            11: res = ((f & 15) << 4) | (f >> 4);
            12: begin res = ((f << 1) & 255) | int'(mc); ec = f[7]; end
            13: begin res = (int'(mc) << 7) | (f >> 1); ec = f[0]; end
            14: begin res = f & ~(1 << b) & 255; tgt = 2; end
            15: begin res = f | (1 << b); tgt = 2; end
            16: begin tgt = 0; sk = ((f >> b) & 1) == 0; end
            17: begin tgt = 0; sk = ((f >> b) & 1) == 1; end
            18: begin res = (f + 1) & 255; sk = res == 0; end
            19: begin res = (f + 255) & 255; sk = res == 0; end
            default: tgt = 0;
        endcase
        if (setz) ez = (res == 0);
        @(negedge clk);
        valid_i = 1'b1; op_i = code[4:0]; use_lit_i = lit; dest_f_i = d;
        w_i = w[7:0]; file_i = f[7:0]; lit_i = k[7:0]; bit_i = b[2:0];
        #1;
        if (tgt != 0) chk({tag, " result"}, result_o, res);
        chk({tag, " wr_w"}, wr_w_o, (tgt == 3) || (tgt == 1 && !d));
        chk({tag, " wr_f"}, wr_f_o, (tgt == 2) || (tgt == 1 && d));
        chk({tag, " skip"}, skip_o, sk);
        @(posedge clk); #1;
        valid_i = 1'b0;
        mc = ec; mdc = edc; mz = ez;
        chk({tag, " C"}, carry_o, mc);
        chk({tag, " DC"}, dcarry_o, mdc);
        chk({tag, " Z"}, zero_o, mz);
    endtask

    // stimulus with valid low: nothing may change
    task automatic idle(int code, int f);
        @(negedge clk);
        valid_i = 1'b0; op_i = code[4:0]; file_i = f[7:0]; w_i = 8'h01;
        #1;
        chk("R11 idle wr_w", wr_w_o, 0);
        chk("R11 idle wr_f", wr_f_o, 0);
        chk("R11 idle skip", skip_o, 0);
        @(posedge clk); #1;
        chk("R11 idle flags", {carry_o, dcarry_o, zero_o}, {mc, mdc, mz});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset C", carry_o, 0);
        chk("R1 reset DC", dcarry_o, 0);
        chk("R1 reset Z", zero_o, 0);
        chk("R1 no write", {wr_w_o, wr_f_o, skip_o}, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 after reset", {carry_o, dcarry_o, zero_o}, 0);

        for (int w = 0; w < 256; w += 7)
            for (int f = 0; f < 256; f++) run(0, 0, f[0], w, f, 0, 0, "R2");
        for (int w = 0; w < 256; w += 11)
            for (int k = 0; k < 256; k++) run(0, 1, k[1], w, 0, k, 0, "R2");
        for (int w = 0; w < 256; w += 7)
            for (int f = 0; f < 256; f++) run(1, 0, f[0], w, f, 0, 0, "R3");
        for (int w = 0; w < 256; w += 11)
            for (int k = 0; k < 256; k++) run(1, 1, k[0], w, 0, k, 0, "R3");

        for (int f = 0; f < 256; f++) begin
            int w = (f * 37 + 5) & 255;
            run(2, f[0], f[1], w, f, f ^ 8'h5A, 0, "R4");
            run(3, f[0], f[1], w & f, f, f, 0, "R4");
            run(4, f[0], f[1], f, f, f, 0, "R4");
            run(5, f[0], f[1], w, f, f, 0, "R4");
            run(6, 0, f[1], f, w, 0, 0, "R4");
            run(7, 0, f[0], w, f, 0, 0, "R4");
            run(8, 0, f[0], w, f, 0, 0, "R4");
            run(9, 0, f[1], w, f, 0, 0, "R4");
            run(10, 0, f[0], w, f, 0, 0, "R4");
        end

        for (int f = 0; f < 256; f++) begin
            run(12, 0, f[0], 0, f, 0, 0, "R5");
            run(12, 0, f[1], 0, f ^ 8'h81, 0, 0, "R5");
            run(13, 0, f[0], 0, f, 0, 0, "R5");
            run(0, 0, 0, 8'h80, f, 0, 0, "R5 carry seed");
            run(13, 0, f[2], 0, f, 0, 0, "R5");
        end

        for (int f = 0; f < 256; f++) begin
            run(0, 0, 0, 8'h0F, f, 0, 0, "R6 flag seed");
            run(11, 0, f[0], 0, f, 0, 0, "R6");
        end

        for (int f = 0; f < 256; f++)
            for (int b = 0; b < 8; b++) begin
                run(14, 0, b[0], 0, f, 0, b, "R7");
                run(15, 0, !b[0], 0, f, 0, b, "R7");
                run(16, 0, 0, 0, f, 0, b, "R8");
                run(17, 0, 1, 0, f, 0, b, "R8");
            end

        for (int f = 0; f < 256; f++) begin
            run(18, 0, f[0], 0, f, 0, 0, "R9");
            run(19, 0, !f[0], 0, f, 0, 0, "R9");
        end

        for (int k = 0; k < 256; k += 5) begin
            run(0, 1, 1, 3, 0, k, 0, "R10");
            run(5, 1, 1, 3, 0, k, 0, "R10");
            run(6, 0, 0, k, 9, 0, 0, "R10");
        end

        run(1, 0, 0, 8'h40, 8'h10, 0, 0, "R11 flag seed");
        for (int f = 0; f < 256; f += 3) begin
            idle(f % 20, f);
            run(20 + (f % 12), f[0], f[1], f, f, f, f & 7, "R11");
        end

        summary();
        $finish;
    end

endmodule